// File: doc/BRIEF.md
# Score-Adaptive Move Selector

This block picks the next move of an automatic player in a four-position digit game. It takes both players' scores, a game-start flag, the current random digit and the four display digits. For every position it also takes the reward an addition would earn there and the adjacency count such a play would create. All of this information arrives in parallel from the gathering logic. The block evaluates every candidate at once and registers a decision one clock after a decide strobe. The decision is a one-hot position select and either a played or a skip flag. The player never subtracts.

The policy depends on the phase of the game and on the score. At game start it looks for adjacency first and then for zero digits, and it skips if there is nothing worth taking and the random digit is zero. When the player trails or the scores are level, it goes for the largest reward. When it leads, it goes for the largest adjacency, and if there is none it takes the smallest digit showing. Every tie goes to the rightmost position, which is the lowest-numbered one.

Top module: `play_decide`

## Requirements
- R1: While rst_ni is low, sel_o, played_o and skip_o are all 0.
- R2: The outputs carry a decision only in the cycle after a clock edge at which decide_i was high. After an edge with decide_i low, all three outputs are 0.
- R3: Position k (0 = rightmost) uses these fields: digits_i[4k+3:4k], reward_i[8k+7:8k], adj_i[2k+1:2k] and sel_o[k]. In a decision cycle exactly one of played_o and skip_o is 1. played_o comes with exactly one sel_o bit set, and skip_o comes with sel_o = 0.
- R4: When start_i is 0 and own_score_i <= opp_score_i (level scores included), the block plays the position with the largest reward. Ties go to the lowest index.
- R5: When start_i is 0, own_score_i > opp_score_i and some adjacency is nonzero, the block plays the position with the largest adjacency. Ties go to the lowest index.
- R6: When start_i is 0, own_score_i > opp_score_i and every adjacency is 0, the block plays the lowest-indexed position holding the smallest digit. This is the rightmost zero whenever a zero is showing.
- R7: When start_i is 1 and some adjacency is nonzero, the block applies the largest-adjacency rule, whatever the scores.
- R8: When start_i is 1, every adjacency is 0 and rand_digit_i is 0, the block skips.
- R9: When start_i is 1, every adjacency is 0 and rand_digit_i is nonzero, the block plays the rightmost zero digit. If no zero is showing, it plays the lowest-indexed smallest digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| decide_i | input | 1 | Strobe that asks for a decision |
| start_i | input | 1 | The game is in its opening phase |
| own_score_i | input | 8 | Automatic player's score, unsigned |
| opp_score_i | input | 8 | Opponent's score, unsigned |
| rand_digit_i | input | 4 | Current random digit |
| digits_i | input | 16 | Display digits, 4 bits per position |
| reward_i | input | 32 | Addition reward per position, 8 bits each |
| adj_i | input | 8 | Adjacency count per position, 2 bits each |
| sel_o | output | 4 | One-hot selected position |
| played_o | output | 1 | A position was played |
| skip_o | output | 1 | The turn was skipped |

## Verification
The hardest situations to reach are ties, because random full-range rewards or adjacencies almost never match across positions. Without ties the rightmost rule is never tested. The stimulus therefore draws rewards and digits from a range of four values and sweeps every subset of positions that carry an adjacency. It sweeps this for each start phase, for each score relation (behind, level, ahead) and for both a zero and a nonzero random digit. This makes equal maxima, equal minima and the all-zero-adjacency fallbacks common cases.

// File: rtl/play_decide_pkg.sv
package play_decide_pkg;
  typedef enum logic [1:0] {
    MODE_REWARD = 2'd0,
    MODE_ADJ    = 2'd1,
    MODE_DIGIT  = 2'd2,
    MODE_SKIP   = 2'd3
  } play_mode_e;
endpackage

// File: rtl/play_pick.sv
// Chooses the max (or min) of N values; ties go to the lowest index.
module play_pick #(
  parameter int N        = 4,
  parameter int W        = 8,
  parameter bit PICK_MAX = 1'b1
) (
  input  logic [N*W-1:0] vals_i,
  output logic [N-1:0]   onehot_o,
  output logic [W-1:0]   val_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [W-1:0]     vals [N];
  logic [IDX_W-1:0] best_idx;

  for (genvar g = 0; g < N; g++) begin : g_unpack
    assign vals[g] = vals_i[g*W +: W];
  end

  always_comb begin
    best_idx = IDX_W'(N-1);
    val_o    = vals[N-1];
    for (int i = N-2; i >= 0; i--) begin
      if (PICK_MAX ? (vals[i] >= val_o) : (vals[i] <= val_o)) begin
        best_idx = IDX_W'(i);
        val_o    = vals[i];
      end
    end
  end

  always_comb begin
    onehot_o           = '0;
    onehot_o[best_idx] = 1'b1;
  end
endmodule

// File: rtl/play_mode.sv
module play_mode
  import play_decide_pkg::*;
#(
  parameter int SCORE_W = 8
) (
  input  logic               start_i,
  input  logic [SCORE_W-1:0] own_score_i,
  input  logic [SCORE_W-1:0] opp_score_i,
  input  logic               any_adj_i,
  input  logic               rand_zero_i,
  output play_mode_e         mode_o
);
  always_comb begin
    if (start_i) begin
      if (any_adj_i)        mode_o = MODE_ADJ;
      else if (rand_zero_i) mode_o = MODE_SKIP;
      else                  mode_o = MODE_DIGIT;
    end else if (own_score_i <= opp_score_i) begin
      mode_o = MODE_REWARD;   // level scores play as if behind
    end else if (any_adj_i) begin
      mode_o = MODE_ADJ;
    end else begin
      mode_o = MODE_DIGIT;    // smallest digit is the rightmost zero when one exists
    end
  end
endmodule

// File: rtl/play_decide.sv
module play_decide
  import play_decide_pkg::*;
#(
  parameter int NUM_POS  = 4,
  parameter int DIGIT_W  = 4,
  parameter int SCORE_W  = 8,
  parameter int REWARD_W = 8,
  parameter int ADJ_W    = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          decide_i,
  input  logic                          start_i,
  input  logic [SCORE_W-1:0]            own_score_i,
  input  logic [SCORE_W-1:0]            opp_score_i,
  input  logic [DIGIT_W-1:0]            rand_digit_i,
  input  logic [NUM_POS*DIGIT_W-1:0]    digits_i,
  input  logic [NUM_POS*REWARD_W-1:0]   reward_i,
  input  logic [NUM_POS*ADJ_W-1:0]      adj_i,
  output logic [NUM_POS-1:0]            sel_o,
  output logic                          played_o,
  output logic                          skip_o
);
  logic [NUM_POS-1:0]  rwd_sel, adj_sel, dig_sel;
  logic [REWARD_W-1:0] rwd_best;
  logic [ADJ_W-1:0]    adj_best;
  logic [DIGIT_W-1:0]  dig_best;
  logic                any_adj;
  play_mode_e          mode;
  logic [NUM_POS-1:0]  sel_d;

  assign any_adj = |adj_i;

  play_pick #(.N(NUM_POS), .W(REWARD_W), .PICK_MAX(1'b1)) u_rwd_pick (
    .vals_i(reward_i), .onehot_o(rwd_sel), .val_o(rwd_best)
  );
  play_pick #(.N(NUM_POS), .W(ADJ_W), .PICK_MAX(1'b1)) u_adj_pick (
    .vals_i(adj_i), .onehot_o(adj_sel), .val_o(adj_best)
  );
  play_pick #(.N(NUM_POS), .W(DIGIT_W), .PICK_MAX(1'b0)) u_dig_pick (
    .vals_i(digits_i), .onehot_o(dig_sel), .val_o(dig_best)
  );

  play_mode #(.SCORE_W(SCORE_W)) u_mode (
    .start_i     (start_i),
    .own_score_i (own_score_i),
    .opp_score_i (opp_score_i),
    .any_adj_i   (any_adj),
    .rand_zero_i (rand_digit_i == '0),
    .mode_o      (mode)
  );

  always_comb begin
    unique case (mode)
      MODE_REWARD: sel_d = rwd_sel;
      MODE_ADJ:    sel_d = adj_sel;
      MODE_DIGIT:  sel_d = dig_sel;
      default:     sel_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o    <= '0;
      played_o <= 1'b0;
      skip_o   <= 1'b0;
    end else if (decide_i) begin
      sel_o    <= sel_d;
      played_o <= (mode != MODE_SKIP);
      skip_o   <= (mode == MODE_SKIP);
    end else begin
      sel_o    <= '0;
      played_o <= 1'b0;
      skip_o   <= 1'b0;
    end
  end

  // R3
  excl_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(played_o && skip_o));

  // R3
  played_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    played_o |-> $countones(sel_o) == 1);

  // R3
  skip_nosel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> sel_o == '0);

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !decide_i |=> (sel_o == '0 && !played_o && !skip_o));

  // R2
  decide_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    decide_i |=> (played_o || skip_o));

  // R8
  start_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide_i && start_i && adj_i == '0 && rand_digit_i == '0) |=> skip_o);

  // R7
  start_adj_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decide_i && start_i && adj_i != '0) |=> played_o);
endmodule

// File: tb/play_decide_tb_top.sv
`timescale 1ns/1ps
module play_decide_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        decide = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  own = '0, opp = '0;
  logic [3:0]  rnd = '0;
  logic [15:0] digits = '0;
  logic [31:0] reward = '0;
  logic [7:0]  adj = '0;
  logic [3:0]  sel;
  logic        played, skip;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  play_decide dut_i (
    .clk_i(clk), .rst_ni(rst_n), .decide_i(decide), .start_i(start),
    .own_score_i(own), .opp_score_i(opp), .rand_digit_i(rnd),
    .digits_i(digits), .reward_i(reward), .adj_i(adj),
    .sel_o(sel), .played_o(played), .skip_o(skip)
  );

  function automatic int best_of(input int v0, v1, v2, v3, input bit want_max);
    int v[4];
    int b = 0;
    v[0] = v0; v[1] = v1; v[2] = v2; v[3] = v3;
    for (int i = 1; i < 4; i++)
      if (want_max ? (v[i] > v[b]) : (v[i] < v[b])) b = i;
    return b;
  endfunction

  task automatic check(input string req, input logic [3:0] es, input logic ep, input logic ek);
    vectors++;
    if (sel !== es || played !== ep || skip !== ek) begin
      fails++;
      $display("FAIL %s: sel=%b played=%b skip=%b expected sel=%b played=%b skip=%b",
               req, sel, played, skip, es, ep, ek);
    end
  endtask

  task automatic apply();
    string req;
    int idx;
    bit adj_any, do_skip;
    logic [3:0] es;
    adj_any = (adj != 0);
    do_skip = 1'b0;
    idx = 0;
    if (start) begin
      if (adj_any) begin
        req = "R7";
        idx = best_of(adj[1:0], adj[3:2], adj[5:4], adj[7:6], 1'b1);
      end else if (rnd == 0) begin
        req = "R8";
        do_skip = 1'b1;
      end else begin
        req = "R9";
        idx = best_of(digits[3:0], digits[7:4], digits[11:8], digits[15:12], 1'b0);
      end
    end else if (own <= opp) begin
      req = "R4";
      idx = best_of(reward[7:0], reward[15:8], reward[23:16], reward[31:24], 1'b1);
    end else if (adj_any) begin
      req = "R5";
      idx = best_of(adj[1:0], adj[3:2], adj[5:4], adj[7:6], 1'b1);
    end else begin
      req = "R6";
      idx = best_of(digits[3:0], digits[7:4], digits[11:8], digits[15:12], 1'b0);
    end
    es = do_skip ? 4'b0000 : (4'b0001 << idx);
    decide = 1'b1;
    @(negedge clk);
    decide = 1'b0;
    check(req, es, !do_skip, do_skip);
    @(negedge clk);
    check("R2", 4'b0000, 1'b0, 1'b0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check("R1", 4'b0000, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: all rewards equal -> position 0
    start = 0; own = 10; opp = 10; reward = {4{8'd7}}; adj = '0; digits = 16'h1234; rnd = 3;
    apply();
    // R5: equal adjacency -> position 0
    own = 200; opp = 3; adj = 8'b10_10_10_10;
    apply();
    // R6: zero on positions 3 and 1 -> position 1
    adj = '0; digits = 16'h0504;
    apply();
    // R8: start, no adjacency, random digit zero
    start = 1; rnd = 0; own = 0; opp = 0;
    apply();
    // R7: start with adjacency beats random-zero skip
    adj = 8'b01_00_00_00;
    apply();
    // R9: start, no zero digit -> smallest, rightmost
    adj = '0; rnd = 9; digits = 16'h3535;
    apply();
    // R4: behind at max score
    start = 0; own = 254; opp = 255; reward = {8'd255, 8'd1, 8'd255, 8'd0};
    apply();

    // Sweep: phase x score relation x random digit x adjacency subset x small-range values
    for (int st = 0; st < 2; st++)
      for (int rel = 0; rel < 3; rel++)
        for (int rz = 0; rz < 2; rz++)
          for (int ap = 0; ap < 16; ap++)
            for (int rep = 0; rep < 8; rep++) begin
              start = st[0];
              own = 8'($urandom_range(1, 254));
              opp = (rel == 0) ? own + 8'd1 : (rel == 1) ? own : own - 8'd1;
              rnd = rz ? 4'($urandom_range(1, 9)) : 4'd0;
              for (int k = 0; k < 4; k++) begin
                adj[2*k +: 2]    = ap[k] ? 2'($urandom_range(1, 3)) : 2'd0;
                reward[8*k +: 8] = (rep[0]) ? 8'($urandom_range(0, 3)) : 8'($urandom_range(0, 255));
                digits[4*k +: 4] = (rep[1]) ? 4'($urandom_range(0, 3)) : 4'($urandom_range(1, 9));
              end
              apply();
            end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule